// File: doc/BRIEF.md
# Serial Configuration Register Port

This block receives control settings over a three-wire, write-only link made of an active-low chip select, a serial clock and a serial data line. While chip select is low, every rising edge of the serial clock pushes one bit into a shadow register, most significant bit first. A frame is one start bit with a fixed value followed by a seven-bit data field. The received bits stay in the serial-clock domain until chip select returns high.

The rising edge of chip select asks for a commit. That request passes into the sampling-clock domain through a two-flop synchronizer and an edge detector. The data field is loaded into the active register only when the frame had exactly the right number of clock edges and the correct start value. Any other frame is dropped, and the active register keeps its old value. The active register drives the control word and two decoded mode outputs: the word bit order of the serializer and doubled clock-driver current.

Top module: `serial_cfg_port`

## Requirements
- R1: While rst_n is low, and after it is released, cfg_word_o is 0, lsb_first_o is 0 (most significant bit first) and drive_boost_o is 0. A frame of zero bits sent after reset leaves these values in place.
- R2: Bits are taken most significant first. The first bit after the start bit lands in cfg_word_o[6] and the last bit lands in cfg_word_o[0].
- R3: A frame of exactly 8 serial-clock rising edges under chip select, whose first bit is 1, loads the 7 remaining bits into cfg_word_o. This holds for every data value.
- R4: A frame of 0 to 7 serial-clock edges leaves all outputs unchanged.
- R5: A frame of more than 8 serial-clock edges leaves all outputs unchanged, even when its last 8 bits form a valid frame.
- R6: An 8-bit frame whose first bit is 0 leaves all outputs unchanged.
- R7: After cs_n rises half a sampling-clock period before an edge, the outputs keep their old value through the second following rising edge of smp_clk and show the new value after the third.
- R8: The outputs do not change while cs_n is low, even after a complete frame has been shifted in.
- R9: lsb_first_o equals cfg_word_o[0] (1 means least significant bit first) and drive_boost_o equals cfg_word_o[1].
- R10: Serial-clock edges while cs_n is high do not touch the shadow register. A later empty frame therefore still commits only the last valid frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk | input | 1 | Sampling clock; the active register is in this domain |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| cs_n | input | 1 | Active-low chip select; a rising edge requests a commit |
| sdi | input | 1 | Serial data input |
| cfg_word_o | output | 7 | Active control word |
| lsb_first_o | output | 1 | Word bit order select |
| drive_boost_o | output | 1 | Doubled clock-driver current select |

## Verification
The bench uses the default parameters: a 7-bit data field behind a single start bit of value 1. With these values all 128 data words can be sent as complete frames, and each one is checked against the word itself and its two decoded mode bits. The small frame length also allows every bit count from zero to twelve edges to be tried, so the frames that are too short, too long and have a bad start bit are all covered. The commit latency is measured edge by edge from a chip-select rise placed at a falling edge of the sampling clock.

// File: rtl/scp_pkg.sv
package scp_pkg;

    typedef enum logic {
        ORDER_MSB_FIRST = 1'b0,
        ORDER_LSB_FIRST = 1'b1
    } bit_order_e;

    localparam int SCP_DATA_W_DEF  = 7;
    localparam int SCP_START_W_DEF = 1;

endpackage

// File: rtl/scp_shift_in.sv
module scp_shift_in #(
    parameter int                 FRAME_W    = 8,
    parameter int                 START_W    = 1,
    parameter logic [START_W-1:0] START_CODE = '1
) (
    input  logic               sclk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sdi,
    output logic [FRAME_W-1:0] shadow_o,
    output logic               valid_o
);

    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] shadow;
        logic               valid;
    } shift_st_t;

    shift_st_t        st_d, st_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             cnt_clr;

    assign cnt_clr = cs_n | ~rst_n;

    always_comb begin
        st_d  = st_q;
        cnt_d = (cnt_q == CNT_W'(CNT_MAX)) ? cnt_q : cnt_q + 1'b1;
        if (!cs_n) begin
            st_d.shadow = {st_q.shadow[FRAME_W-2:0], sdi};
            st_d.valid  = (cnt_d == CNT_W'(FRAME_W)) &&
                          (st_d.shadow[FRAME_W-1 -: START_W] == START_CODE);
        end
    end

    // The edge counter restarts whenever chip select is high
    always_ff @(posedge sclk or posedge cnt_clr) begin
        if (cnt_clr) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow_o = st_q.shadow;
    assign valid_o  = st_q.valid;

    always_comb begin
        AST_CNT_BOUND: assert (cnt_q <= CNT_W'(CNT_MAX)); // R5
    end

    AST_SHIFT_ORDER: assert property (@(posedge sclk) disable iff (!rst_n)
        !cs_n |=> st_q.shadow[0] == $past(sdi)); // R2

    AST_IDLE_HOLD: assert property (@(posedge sclk) disable iff (!rst_n)
        cs_n |=> $stable(st_q.shadow)); // R10

endmodule

// File: rtl/scp_cs_sync.sv
module scp_cs_sync (
    input  logic smp_clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic rise_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = cs_n;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge smp_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.s2 & ~st_q.prev;

    AST_RISE_SINGLE: assert property (@(posedge smp_clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R7

endmodule

// File: rtl/scp_commit.sv
module scp_commit #(
    parameter int                DATA_W     = 7,
    parameter logic [DATA_W-1:0] RESET_WORD = '0,
    parameter int                LSB_POS    = 0,
    parameter int                BOOST_POS  = 1
) (
    input  logic              smp_clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] word_o,
    output logic              lsb_first_o,
    output logic              boost_o
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } act_st_t;

    act_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit_i && valid_i) st_d.word = data_i;
    end

    always_ff @(posedge smp_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{word: RESET_WORD};
        else        st_q <= st_d;
    end

    assign word_o = st_q.word;

    generate
        if (LSB_POS < DATA_W) begin : g_order
            assign lsb_first_o = st_q.word[LSB_POS];
        end else begin : g_order_fixed
            assign lsb_first_o = scp_pkg::ORDER_MSB_FIRST;
        end
        if (BOOST_POS < DATA_W) begin : g_boost
            assign boost_o = st_q.word[BOOST_POS];
        end else begin : g_boost_fixed
            assign boost_o = 1'b0;
        end
    endgenerate

    AST_NO_STRAY_UPDATE: assert property (@(posedge smp_clk) disable iff (!rst_n)
        !commit_i |=> $stable(st_q.word)); // R8

    AST_DISCARD_BAD: assert property (@(posedge smp_clk) disable iff (!rst_n)
        (commit_i && !valid_i) |=> $stable(st_q.word)); // R4

    AST_LOAD_GOOD: assert property (@(posedge smp_clk) disable iff (!rst_n)
        (commit_i && valid_i) |=> st_q.word == $past(data_i)); // R3

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
    parameter int                 DATA_W     = scp_pkg::SCP_DATA_W_DEF,
    parameter int                 START_W    = scp_pkg::SCP_START_W_DEF,
    parameter logic [START_W-1:0] START_CODE = '1,
    parameter logic [DATA_W-1:0]  RESET_WORD = '0,
    parameter int                 LSB_POS    = 0,
    parameter int                 BOOST_POS  = 1
) (
    input  logic              smp_clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    output logic [DATA_W-1:0] cfg_word_o,
    output logic              lsb_first_o,
    output logic              drive_boost_o
);

    localparam int FRAME_W = START_W + DATA_W;

    logic [FRAME_W-1:0] shadow;
    logic               shadow_valid;
    logic               commit;

    scp_shift_in #(
        .FRAME_W    (FRAME_W),
        .START_W    (START_W),
        .START_CODE (START_CODE)
    ) i_shift (
        .sclk     (sclk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sdi      (sdi),
        .shadow_o (shadow),
        .valid_o  (shadow_valid)
    );

    scp_cs_sync i_sync (
        .smp_clk (smp_clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .rise_o  (commit)
    );

    scp_commit #(
        .DATA_W     (DATA_W),
        .RESET_WORD (RESET_WORD),
        .LSB_POS    (LSB_POS),
        .BOOST_POS  (BOOST_POS)
    ) i_commit (
        .smp_clk     (smp_clk),
        .rst_n       (rst_n),
        .commit_i    (commit),
        .valid_i     (shadow_valid),
        .data_i      (shadow[DATA_W-1:0]),
        .word_o      (cfg_word_o),
        .lsb_first_o (lsb_first_o),
        .boost_o     (drive_boost_o)
    );

endmodule

// File: tb/test_serial_cfg_port.sv
module test_serial_cfg_port;

    logic       smp_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       sclk    = 1'b0;
    logic       cs_n    = 1'b1;
    logic       sdi     = 1'b0;
    logic [6:0] cfg_word_o;
    logic       lsb_first_o;
    logic       drive_boost_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [6:0] cur;

    serial_cfg_port i_serial_cfg_port (
        .smp_clk       (smp_clk),
        .rst_n         (rst_n),
        .sclk          (sclk),
        .cs_n          (cs_n),
        .sdi           (sdi),
        .cfg_word_o    (cfg_word_o),
        .lsb_first_o   (lsb_first_o),
        .drive_boost_o (drive_boost_o)
    );

    always #4 smp_clk = ~smp_clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [6:0] exp);
        check({req, " word"}, {25'd0, cfg_word_o}, {25'd0, exp});
        check({req, " order"}, {31'd0, lsb_first_o}, {31'd0, exp[0]});
        check({req, " boost"}, {31'd0, drive_boost_o}, {31'd0, exp[1]});
    endtask

    // Shifts the low n bits of pat, highest first; leaves cs_n low
    task automatic shift_bits(input logic [15:0] pat, input int n);
        @(negedge smp_clk) cs_n = 1'b0;
        #15;
        for (int i = n - 1; i >= 0; i--) begin
            sdi = pat[i];
            #15 sclk = 1'b1;
            #30 sclk = 1'b0;
            #15;
        end
    endtask

    task automatic send(input logic [15:0] pat, input int n);
        shift_bits(pat, n);
        @(negedge smp_clk) cs_n = 1'b1;
        repeat (4) @(posedge smp_clk);
        #1;
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #50;
        check_out("R1 during reset", 7'h00);
        @(negedge smp_clk) rst_n = 1'b1;
        #20;
        check_out("R1 after reset", 7'h00);
        send(16'h0, 0);
        check_out("R1 empty frame after reset", 7'h00);

        // R7 commit latency, R8 no change while selected
        shift_bits({8'h00, 1'b1, 7'h55}, 8);
        repeat (3) @(posedge smp_clk);
        #1;
        check_out("R8 full frame cs low", 7'h00);
        @(negedge smp_clk) cs_n = 1'b1;
        repeat (2) @(posedge smp_clk);
        #1;
        check_out("R7 two edges", 7'h00);
        @(posedge smp_clk);
        #1;
        check_out("R7 third edge", 7'h55);
        repeat (2) @(posedge smp_clk);

        // R2 MSB first placement
        send({8'h00, 1'b1, 7'h40}, 8);
        check_out("R2 first data bit", 7'h40);
        send({8'h00, 1'b1, 7'h01}, 8);
        check_out("R2 last data bit", 7'h01);

        // R3 and R9 exhaustive sweep
        for (int v = 0; v < 128; v++) begin
            send({8'h00, 1'b1, 7'(v)}, 8);
            check_out("R3 R9 sweep", 7'(v));
        end
        cur = 7'h7F;

        // R4 short frames
        for (int n = 0; n < 8; n++) begin
            send({8'h00, 1'b1, 7'h2A}, n);
            check_out("R4 short frame", cur);
        end

        // R5 long frames ending in a valid pattern
        for (int n = 9; n <= 12; n++) begin
            send({8'h00, 1'b1, 7'h33}, n);
            check_out("R5 long frame", cur);
        end

        // R6 bad start bit
        send({8'h00, 1'b0, 7'h11}, 8);
        check_out("R6 bad start", cur);

        // R10 stray serial clocks while deselected
        send({8'h00, 1'b1, 7'h26}, 8);
        check_out("R10 setup", 7'h26);
        for (int k = 0; k < 5; k++) begin
            sdi = k[0];
            #15 sclk = 1'b1;
            #30 sclk = 1'b0;
            #15;
        end
        send(16'h0, 0);
        check_out("R10 stray clocks", 7'h26);

        // R1 reset restores defaults
        @(negedge smp_clk) rst_n = 1'b0;
        #20;
        check_out("R1 reset again", 7'h00);
        @(negedge smp_clk) rst_n = 1'b1;
        send(16'h0, 0);
        check_out("R1 empty frame after second reset", 7'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule